// File: doc/BRIEF.md
# Core Fuse/Split Mode Controller

This controller moves a group of unit cores between two operating modes: independent, where each core runs its own thread, and fused, where two or four cores act as one wider core. A decoded fuse or split instruction raises a one-cycle request. The controller then runs the matching sequence and drives strobes to the surrounding units. For a fuse, those are the instruction pipeline flush, the instruction cache flush, and the reconfiguration of the fetch unit, the steering unit and the instruction cache tag layout.

The two directions use different sequences. A fuse first checks whether it can be granted. A granted fuse flushes at once and then reconfigures. A fuse that cannot be granted is dropped, and the controller reports that with a one-cycle rejection pulse. A split flushes nothing. It waits until every core of the fused group reports that its in-flight work has drained, and only then reconfigures. The data cache has no strobe, because no mode change touches it.

The controller presents the current mode through two outputs: whether the group is fused, and whether the fused group has four cores. It also gives a one-cycle completion pulse for every request it acts on.

Top module: `fusion_mode_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the mode is independent (mode_fused = 0, mode_group4 = 0) and the outputs flush_pipe, flush_icache, recfg_fetch, recfg_steer, recfg_itag, done and rejected are all 0.
- R2: A fuse request accepted in independent mode drives flush_pipe and flush_icache high together. They rise in the cycle after the request and stay high for exactly one cycle.
- R3: recfg_fetch, recfg_steer and recfg_itag rise together and stay high for exactly RECFG_CYCLES (default 2) consecutive cycles. For a fuse they start in the cycle after the flush. For a split they start in the cycle after the drain condition is seen.
- R4: done is high for one cycle, in the cycle after the last reconfiguration cycle. The mode outputs take their new values in that same cycle. mode_group4 is 1 when group_four was 1 at the fuse request (4-core group) and 0 when it was 0 (2-core group).
- R5: A fuse request made in independent mode is dropped when fusable is 0, or when core_busy is 1 for any core of the requested group. The group is cores 0..1 for a 2-core group and cores 0..3 for a 4-core group. When a fuse is dropped, rejected is high for exactly the one following cycle, no flush, reconfiguration or done strobe occurs, and the mode stays independent.
- R6: A split request made in fused mode raises no flush strobe. It holds reconfiguration back until core_empty is 1 for every core of the fused group. core_empty bits of cores outside the group are ignored.
- R7: A fuse request while already fused, or a split request while already independent, gives done in the next cycle with no flush or reconfiguration strobe and no change of mode.
- R8: Requests are accepted only in the idle state, and requests that arrive during a sequence are ignored. When fuse_req and split_req are high together, fuse takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fuse_req | input | 1 | Decoded fuse instruction, one-cycle request |
| split_req | input | 1 | Decoded split instruction, one-cycle request |
| group_four | input | 1 | Requested group size for a fuse: 0 = two cores, 1 = four cores |
| fusable | input | 1 | External check that a fuse may be granted |
| core_busy | input | NUM_CORES | Per-core flag, core is held by other work |
| core_empty | input | NUM_CORES | Per-core flag, no instructions in flight |
| flush_pipe | output | 1 | Instruction pipeline flush strobe |
| flush_icache | output | 1 | Instruction cache flush strobe |
| recfg_fetch | output | 1 | Fetch unit reconfiguration strobe |
| recfg_steer | output | 1 | Steering unit reconfiguration strobe |
| recfg_itag | output | 1 | Instruction cache tag layout reconfiguration strobe |
| mode_fused | output | 1 | Current mode is fused |
| mode_group4 | output | 1 | Current fused group has four cores |
| done | output | 1 | One-cycle completion pulse |
| rejected | output | 1 | One-cycle pulse when a fuse is dropped |

## Verification
All outputs come from registers. Counting from the clock edge that samples a request, a granted fuse shows its flush one cycle later, its reconfiguration in cycles two and three, and done together with the new mode in cycle four. A rejection or a no-op completion shows in cycle one. A split shows its reconfiguration one cycle after the edge that first sees the group empty, and done two cycles after that. The bench drives inputs on the falling edge and compares the whole output vector at every following falling edge against a sequence computed from these counts. In this way both late and early strobes are reported. The sweeps cover every busy pattern and every empty pattern for both group sizes.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_DRAIN,
        ST_RECFG,
        ST_DONE
    } fmc_state_e;

    typedef struct packed {
        fmc_state_e state;
        logic       op_fuse;   // sequence in progress is a fuse
        logic       fused;     // current mode
        logic       grp4;      // fused group holds four cores
        logic       rej;       // rejection pulse
    } fmc_regs_t;

endpackage

// File: rtl/fmc_group_eval.sv
module fmc_group_eval #(
    parameter int NUM_CORES   = 4,
    parameter int SMALL_GROUP = 2,
    parameter int LARGE_GROUP = 4
) (
    input  logic                 grp_large,
    input  logic [NUM_CORES-1:0] core_busy,
    input  logic [NUM_CORES-1:0] core_empty,
    output logic                 any_busy,
    output logic                 all_empty
);

    logic [NUM_CORES-1:0] member;

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_member
        localparam bit IN_SMALL = (i < SMALL_GROUP);
        localparam bit IN_LARGE = (i < LARGE_GROUP);
        assign member[i] = IN_SMALL | (grp_large & IN_LARGE);
    end

    assign any_busy  = |(core_busy & member);
    assign all_empty = &(core_empty | ~member);

endmodule

// File: rtl/fmc_strobe_timer.sv
module fmc_strobe_timer #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);

    localparam int W = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        last  = run && (cnt_q == W'(HOLD - 1));
        cnt_d = '0;
        if (run && !last) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/fusion_mode_ctrl.sv
module fusion_mode_ctrl
    import fmc_pkg::*;
#(
    parameter int NUM_CORES    = 4,
    parameter int RECFG_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fuse_req,
    input  logic                 split_req,
    input  logic                 group_four,
    input  logic                 fusable,
    input  logic [NUM_CORES-1:0] core_busy,
    input  logic [NUM_CORES-1:0] core_empty,
    output logic                 flush_pipe,
    output logic                 flush_icache,
    output logic                 recfg_fetch,
    output logic                 recfg_steer,
    output logic                 recfg_itag,
    output logic                 mode_fused,
    output logic                 mode_group4,
    output logic                 done,
    output logic                 rejected
);

    localparam int SMALL_GROUP = 2;
    localparam int LARGE_GROUP = 4;

    fmc_regs_t r_d, r_q;
    logic      grp_sel;
    logic      any_busy;
    logic      all_empty;
    logic      recfg_last;

    // Independent: evaluate the requested size; fused: the stored size.
    assign grp_sel = r_q.fused ? r_q.grp4 : group_four;

    fmc_group_eval #(
        .NUM_CORES  (NUM_CORES),
        .SMALL_GROUP(SMALL_GROUP),
        .LARGE_GROUP(LARGE_GROUP)
    ) u_group (
        .grp_large (grp_sel),
        .core_busy (core_busy),
        .core_empty(core_empty),
        .any_busy  (any_busy),
        .all_empty (all_empty)
    );

    fmc_strobe_timer #(
        .HOLD(RECFG_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (r_q.state == ST_RECFG),
        .last (recfg_last)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rej = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (fuse_req) begin
                    if (r_q.fused) begin
                        r_d.state = ST_DONE;
                    end else if (!fusable || any_busy) begin
                        r_d.rej = 1'b1;
                    end else begin
                        r_d.state   = ST_FLUSH;
                        r_d.op_fuse = 1'b1;
                        r_d.grp4    = group_four;
                    end
                end else if (split_req) begin
                    if (!r_q.fused) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.state   = ST_DRAIN;
                        r_d.op_fuse = 1'b0;
                    end
                end
            end
            ST_FLUSH: r_d.state = ST_RECFG;
            ST_DRAIN: begin
                if (all_empty) begin
                    r_d.state = ST_RECFG;
                end
            end
            ST_RECFG: begin
                if (recfg_last) begin
                    r_d.state = ST_DONE;
                    r_d.fused = r_q.op_fuse;
                end
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign flush_pipe   = (r_q.state == ST_FLUSH);
    assign flush_icache = (r_q.state == ST_FLUSH);
    assign recfg_fetch  = (r_q.state == ST_RECFG);
    assign recfg_steer  = (r_q.state == ST_RECFG);
    assign recfg_itag   = (r_q.state == ST_RECFG);
    assign done         = (r_q.state == ST_DONE);
    assign rejected     = r_q.rej;
    assign mode_fused   = r_q.fused;
    assign mode_group4  = r_q.fused & r_q.grp4;

endmodule

// File: rtl/fmc_checker.sv
module fmc_checker (
    input logic clk,
    input logic rst_n,
    input logic fuse_req,
    input logic flush_pipe,
    input logic flush_icache,
    input logic recfg_fetch,
    input logic recfg_steer,
    input logic recfg_itag,
    input logic mode_fused,
    input logic done,
    input logic rejected
);

    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pipe |=> !flush_pipe); // R2
    AST_FLUSH_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pipe == flush_icache); // R2
    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_pipe) |-> ($past(fuse_req) && !$past(mode_fused))); // R2
    AST_FLUSH_TO_RECFG: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pipe |=> recfg_fetch); // R3
    AST_RECFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recfg_fetch) |=> recfg_fetch); // R3
    AST_RECFG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        recfg_fetch |-> (recfg_steer && recfg_itag)); // R3
    AST_DONE_AFTER_RECFG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(recfg_fetch) |-> done); // R4
    AST_MODE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fused != $past(mode_fused)) |-> done); // R4
    AST_REJ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |=> !rejected); // R5
    AST_REJ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> (!flush_pipe && !recfg_fetch && !done && !mode_fused)); // R5
    AST_SPLIT_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fused |-> !flush_pipe); // R6

endmodule

bind fusion_mode_ctrl fmc_checker u_chk (.*);

// File: tb/fusion_mode_ctrl_test.sv
module fusion_mode_ctrl_test;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fuse_req = 1'b0;
    logic         split_req = 1'b0;
    logic         group_four = 1'b0;
    logic         fusable = 1'b0;
    logic [N-1:0] core_busy = '0;
    logic [N-1:0] core_empty = '1;
    logic flush_pipe, flush_icache, recfg_fetch, recfg_steer, recfg_itag;
    logic mode_fused, mode_group4, done, rejected;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fusion_mode_ctrl #(.NUM_CORES(N), .RECFG_CYCLES(2)) uut (
        .clk(clk), .rst_n(rst_n), .fuse_req(fuse_req), .split_req(split_req),
        .group_four(group_four), .fusable(fusable), .core_busy(core_busy),
        .core_empty(core_empty), .flush_pipe(flush_pipe), .flush_icache(flush_icache),
        .recfg_fetch(recfg_fetch), .recfg_steer(recfg_steer), .recfg_itag(recfg_itag),
        .mode_fused(mode_fused), .mode_group4(mode_group4), .done(done), .rejected(rejected)
    );

    // Vector order: flush_pipe, flush_icache, recfg x3, done, rejected, mode_fused, mode_group4
    function automatic logic [8:0] ov(input logic fl, input logic rf, input logic dn,
                                      input logic rj, input logic mf, input logic mg);
        return {fl, fl, rf, rf, rf, dn, rj, mf, mg};
    endfunction

    function automatic logic [8:0] obs();
        return {flush_pipe, flush_icache, recfg_fetch, recfg_steer, recfg_itag,
                done, rejected, mode_fused, mode_group4};
    endfunction

    task automatic cmp(input string tag, input logic [8:0] exp);
        vectors++;
        if (obs() !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, obs(), exp, $time);
        end
    endtask

    task automatic chk(input string tag, input logic [8:0] exp);
        @(negedge clk);
        cmp(tag, exp);
    endtask

    function automatic logic [N-1:0] grp_mask(input logic g4);
        return g4 ? 4'hF : 4'h3;
    endfunction

    // Granted fuse from independent mode; starts at a falling edge.
    task automatic fuse_ok(input logic g4);
        fuse_req = 1'b1; group_four = g4; fusable = 1'b1; core_busy = '0;
        chk("R2 flush", ov(1, 0, 0, 0, 0, 0));
        fuse_req = 1'b0;
        chk("R3 reconfig 1", ov(0, 1, 0, 0, 0, 0));
        chk("R3 reconfig 2", ov(0, 1, 0, 0, 0, 0));
        chk("R4 done fused", ov(0, 0, 1, 0, 1, g4));
        chk("R4 idle fused", ov(0, 0, 0, 0, 1, g4));
    endtask

    // Split from fused mode with empty pattern p; full empty is released later.
    task automatic split_run(input logic g4, input logic [N-1:0] p);
        logic ready;
        ready = ((p & grp_mask(g4)) == grp_mask(g4));
        split_req = 1'b1; core_empty = p;
        chk("R6 drain entry", ov(0, 0, 0, 0, 1, g4));
        split_req = 1'b0;
        if (!ready) begin
            chk("R6 drain hold", ov(0, 0, 0, 0, 1, g4));
            core_empty = '1;
        end
        chk("R3 split reconfig 1", ov(0, 1, 0, 0, 1, g4));
        chk("R3 split reconfig 2", ov(0, 1, 0, 0, 1, g4));
        chk("R4 done split", ov(0, 0, 1, 0, 0, 0));
        chk("R4 idle split", ov(0, 0, 0, 0, 0, 0));
        core_empty = '1;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp("R1 in reset", ov(0, 0, 0, 0, 0, 0));
        rst_n = 1'b1;
        chk("R1 after reset", ov(0, 0, 0, 0, 0, 0));

        // R5 / R2: sweep fusable, group size and every busy pattern
        for (int g = 0; g < 2; g++) begin
            for (int f = 0; f < 2; f++) begin
                for (int b = 0; b < 16; b++) begin
                    logic ok;
                    ok = (f == 1) && ((4'(b) & grp_mask(g[0])) == '0);
                    fuse_req = 1'b1; group_four = g[0]; fusable = f[0]; core_busy = 4'(b);
                    if (ok) begin
                        chk("R2 sweep flush", ov(1, 0, 0, 0, 0, 0));
                        fuse_req = 1'b0; core_busy = '0;
                        chk("R3 sweep reconfig 1", ov(0, 1, 0, 0, 0, 0));
                        chk("R3 sweep reconfig 2", ov(0, 1, 0, 0, 0, 0));
                        chk("R4 sweep done", ov(0, 0, 1, 0, 1, g[0]));
                        chk("R4 sweep idle", ov(0, 0, 0, 0, 1, g[0]));
                        split_run(g[0], '1);
                    end else begin
                        chk("R5 rejected pulse", ov(0, 0, 0, 1, 0, 0));
                        fuse_req = 1'b0; core_busy = '0;
                        chk("R5 rejected cleared", ov(0, 0, 0, 0, 0, 0));
                    end
                end
            end
        end

        // R6: split with every empty pattern, both group sizes
        for (int g = 0; g < 2; g++) begin
            for (int p = 0; p < 16; p++) begin
                fuse_ok(g[0]);
                split_run(g[0], 4'(p));
            end
        end

        // R7: no-op requests
        split_req = 1'b1;
        chk("R7 split while independent", ov(0, 0, 1, 0, 0, 0));
        split_req = 1'b0;
        chk("R7 idle after noop", ov(0, 0, 0, 0, 0, 0));
        fuse_ok(1'b1);
        fuse_req = 1'b1; group_four = 1'b0;
        chk("R7 fuse while fused", ov(0, 0, 1, 0, 1, 1));
        fuse_req = 1'b0;
        chk("R7 mode kept", ov(0, 0, 0, 0, 1, 1));
        split_run(1'b1, '1);

        // R8: request during a sequence is ignored
        fuse_req = 1'b1; group_four = 1'b0; fusable = 1'b1;
        chk("R8 flush", ov(1, 0, 0, 0, 0, 0));
        fuse_req = 1'b0; split_req = 1'b1;
        chk("R8 split ignored in flush", ov(0, 1, 0, 0, 0, 0));
        split_req = 1'b0;
        chk("R8 reconfig 2", ov(0, 1, 0, 0, 0, 0));
        fuse_req = 1'b1; fusable = 1'b0;
        chk("R8 done, fuse ignored", ov(0, 0, 1, 0, 1, 0));
        fuse_req = 1'b0;
        chk("R8 idle fused", ov(0, 0, 0, 0, 1, 0));
        split_run(1'b0, '1);

        // R8: fuse wins over split
        fuse_req = 1'b1; split_req = 1'b1; fusable = 1'b1; group_four = 1'b1;
        chk("R8 priority flush", ov(1, 0, 0, 0, 0, 0));
        fuse_req = 1'b0; split_req = 1'b0;
        chk("R8 priority reconfig", ov(0, 1, 0, 0, 0, 0));
        chk("R8 priority reconfig 2", ov(0, 1, 0, 0, 0, 0));
        chk("R8 priority done", ov(0, 0, 1, 0, 1, 1));

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule